// File: doc/BRIEF.md
# Dual-Edge Non-Retriggerable One-Shot

This block turns input transitions into fixed-length pulses counted in clock cycles. It holds two independent channels. Each channel has three inputs:

- an active-low trigger that fires on its falling edge;
- an active-high trigger that fires on its rising edge;
- an active-low clear.

Each channel drives a complementary pair of outputs. The two triggers gate each other: a falling edge on the active-low trigger counts only while the active-high trigger is high, and the reverse also holds. Once a pulse runs, it always lasts its full programmed length and never stretches.

The clear input cuts a running pulse short and blocks any new pulse while it is low. It can also fire a pulse when it is released. This happens when, during the low period, the triggers were first disturbed (active-low trigger high, or active-high trigger low) and then returned to their enabling levels (active-low low, active-high high). All three inputs pass through a two-flop synchronizer before edge detection.

Each channel has its own pulse length, a 16-bit cycle count. Software-free logic loads it by pulsing the channel's load strobe while the shared width bus carries the value.

Top module: `dual_oneshot`

## Requirements
- R1: After the synchronous reset `rst` is released, every channel shows `q`=0 and `q_n`=1, and no pulse follows unless a trigger occurs.
- R2: `q_n` is the inverse of `q` on every channel in every cycle.
- R3: With `clr_n` high and `trig_b` high, a 1-to-0 change on `trig_a_n` starts a pulse. If the input changes just before clock edge k, `q` is first high after edge k+2.
- R4: With `clr_n` high and `trig_a_n` low, a 0-to-1 change on `trig_b` starts a pulse with the same latency as R3.
- R5: A trigger edge whose gating level is not met starts no pulse. This covers a fall of `trig_a_n` while `trig_b` is low, and a rise of `trig_b` while `trig_a_n` is high.
- R6: A pulse keeps `q` high for exactly N cycles. N is the 16-bit value last loaded with `ld_width`, and the reset default is 4. N=0 produces no pulse.
- R7: Trigger edges that arrive while a pulse runs are ignored, so the pulse length stays N and no second pulse follows.
- R8: Driving `clr_n` low ends a running pulse. `q` falls after the same synchronizer-plus-one latency as in R3. No trigger starts a pulse while `clr_n` stays low.
- R9: A 0-to-1 change on `clr_n` starts a pulse only if three things happened in order while it was low. First `trig_a_n` was high or `trig_b` was low. Then both returned to `trig_a_n`=0 and `trig_b`=1 for at least one sampled cycle. Then `clr_n` rose. A renewed disturbance before the rise cancels the armed state.
- R10: A qualifying `trig_a_n` fall sampled in the same cycle as the `clr_n` rise starts a pulse. There is no recovery gap.
- R11: A channel's clear, triggers and width do not affect the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up state) |
| trig_a_n | input | CHANNELS | Falling-edge trigger, one bit per channel |
| trig_b | input | CHANNELS | Rising-edge trigger, one bit per channel |
| clr_n | input | CHANNELS | Active-low clear, one bit per channel |
| ld_width | input | CHANNELS | Load strobe for that channel's pulse length |
| width_in | input | CW | Pulse length value, shared by all channels |
| q | output | CHANNELS | Pulse output, high during a pulse |
| q_n | output | CHANNELS | Inverse of `q` |

## Verification
The assertions take for granted that the inputs do not change faster than the synchronizer can follow. They also assume that a clear release is judged only on synchronized samples, so any arming sequence must last at least one sampled cycle before the release. The stimulus meets this in three ways:

- it changes inputs only on falling clock edges;
- it holds every input level for several cycles;
- it waits for each pulse to finish before setting up the next pattern, except in the deliberate retrigger and kill cases.

The gating sweep walks all sixteen before/after combinations of the two triggers and predicts from the level equations whether a pulse must appear.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Synchronized view of one channel's inputs.
    typedef struct packed {
        logic a_n;   // falling-edge trigger, idle high
        logic b;     // rising-edge trigger, idle low
        logic r_n;   // active-low clear
    } trig_t;

    localparam int unsigned TRIG_BITS = $bits(trig_t);

    // Reset value: triggers idle, channel held in clear.
    localparam trig_t TRIG_RESET = '{a_n: 1'b1, b: 1'b0, r_n: 1'b0};

    typedef struct packed {
        logic fall_a;
        logic rise_b;
        logic rise_r;
    } edges_t;

    function automatic edges_t find_edges(input trig_t cur, input trig_t prv);
        edges_t e;
        e.fall_a = prv.a_n & ~cur.a_n;
        e.rise_b = ~prv.b & cur.b;
        e.rise_r = ~prv.r_n & cur.r_n;
        return e;
    endfunction

    // Levels that enable the triggers (A low, B high).
    function automatic logic levels_enabling(input trig_t cur);
        return ~cur.a_n & cur.b;
    endfunction

    // Levels that count as a disturbance while clear is low.
    function automatic logic levels_disturbed(input trig_t cur);
        return cur.a_n | ~cur.b;
    endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int unsigned   W       = 3,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= RST_VAL;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= RST_VAL;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/os_edge_gate.sv
module os_edge_gate
    import oneshot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  trig_t cur,
    input  logic  busy,
    output logic  fire,
    output logic  kill
);
    trig_t  prv;
    edges_t ed;
    logic   disturbed;
    logic   armed;
    logic   want_a, want_b, want_r;

    always_ff @(posedge clk) begin
        if (rst) prv <= TRIG_RESET;
        else     prv <= cur;
    end

    assign ed = find_edges(cur, prv);

    // Arming sequence tracked only while the clear is low.
    always_ff @(posedge clk) begin
        if (rst) begin
            disturbed <= 1'b0;
            armed     <= 1'b0;
        end else if (cur.r_n) begin
            disturbed <= 1'b0;
            armed     <= 1'b0;
        end else if (levels_disturbed(cur)) begin
            disturbed <= 1'b1;
            armed     <= 1'b0;
        end else if (disturbed) begin
            armed     <= 1'b1;
        end
    end

    assign want_a = ed.fall_a & cur.b;
    assign want_b = ed.rise_b & ~cur.a_n;
    assign want_r = ed.rise_r & armed & levels_enabling(cur);
    assign fire   = ~busy & cur.r_n & (want_a | want_b | want_r);
    assign kill   = ~cur.r_n;

    // R9: arming can only complete while the clear was low
    p_arm_while_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(!cur.r_n));

    // R9: the armed flag is consumed by the release
    p_arm_consumed_r9: assert property (@(posedge clk) disable iff (rst)
        (armed && cur.r_n) |=> !armed);
endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kill,
    input  logic          start,
    input  logic [CW-1:0] width,
    output logic          busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || kill)        cnt <= '0;
        else if (start)         cnt <= width;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R7: a running count only steps down, never reloads
    p_no_stretch_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && !kill) |=> (cnt == $past(cnt) - 1'b1));

    // R8: clear empties the counter on the next edge
    p_kill_r8: assert property (@(posedge clk) disable iff (rst)
        kill |=> (cnt == '0));

    // R6: an accepted start loads the programmed length
    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !kill && cnt == '0) |=> (cnt == $past(width)));
endmodule

// File: rtl/os_channel.sv
module os_channel
    import oneshot_pkg::*;
#(
    parameter int unsigned   CW        = 16,
    parameter logic [CW-1:0] DEF_WIDTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_n,
    input  logic          b,
    input  logic          r_n,
    input  logic          ld,
    input  logic [CW-1:0] width_in,
    output logic          q,
    output logic          q_n
);
    logic [TRIG_BITS-1:0] raw, synced;
    trig_t                cur;
    logic [CW-1:0]        width_q;
    logic                 fire, kill, busy;

    assign raw = {a_n, b, r_n};

    os_sync #(
        .W       (TRIG_BITS),
        .STAGES  (2),
        .RST_VAL (TRIG_RESET)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    assign cur = trig_t'(synced);

    always_ff @(posedge clk) begin
        if (rst)     width_q <= DEF_WIDTH;
        else if (ld) width_q <= width_in;
    end

    os_edge_gate u_gate (
        .clk  (clk),
        .rst  (rst),
        .cur  (cur),
        .busy (busy),
        .fire (fire),
        .kill (kill)
    );

    os_pulse_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .kill  (kill),
        .start (fire),
        .width (width_q),
        .busy  (busy)
    );

    assign q   = busy;
    assign q_n = ~busy;

    // R8: a sampled-low clear leaves no pulse on the next cycle
    p_low_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        !cur.r_n |=> !q);
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
    parameter int unsigned   CHANNELS  = 2,
    parameter int unsigned   CW        = 16,
    parameter logic [CW-1:0] DEF_WIDTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] trig_a_n,
    input  logic [CHANNELS-1:0] trig_b,
    input  logic [CHANNELS-1:0] clr_n,
    input  logic [CHANNELS-1:0] ld_width,
    input  logic [CW-1:0]       width_in,
    output logic [CHANNELS-1:0] q,
    output logic [CHANNELS-1:0] q_n
);
    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        os_channel #(
            .CW        (CW),
            .DEF_WIDTH (DEF_WIDTH)
        ) u_ch (
            .clk      (clk),
            .rst      (rst),
            .a_n      (trig_a_n[c]),
            .b        (trig_b[c]),
            .r_n      (clr_n[c]),
            .ld       (ld_width[c]),
            .width_in (width_in),
            .q        (q[c]),
            .q_n      (q_n[c])
        );
    end
endmodule

// File: tb/test_dual_oneshot.sv
module test_dual_oneshot;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  a_n, b, r_n, ld;
    logic [15:0] wv;
    logic [1:0]  q, q_n;
    int          n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    dual_oneshot i_dual_oneshot (
        .clk(clk), .rst(rst), .trig_a_n(a_n), .trig_b(b), .clr_n(r_n),
        .ld_width(ld), .width_in(wv), .q(q), .q_n(q_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_width(input int ch, input int n);
        @(negedge clk);
        wv = 16'(n);
        ld[ch] = 1'b1;
        @(negedge clk);
        ld[ch] = 1'b0;
    endtask

    // Observe one channel for win cycles: rising edges, first-rise cycle, high cycles.
    task automatic watch(input int ch, input int win,
                         output int rises, output int first, output int high);
        logic prv;
        logic bad;
        prv   = q[ch];
        bad   = 1'b0;
        rises = 0;
        first = -1;
        high  = 0;
        for (int i = 1; i <= win; i++) begin
            @(negedge clk);
            if (q[ch]) high++;
            if (q[ch] && !prv) begin
                rises++;
                if (first < 0) first = i;
            end
            if (q_n[ch] !== ~q[ch]) bad = 1'b1;
            prv = q[ch];
        end
        check("R2 complement", int'(bad), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int rs, fs, hs, r2, f2, h2, r3, f3, h3;
        rst = 1'b1; a_n = 2'b11; b = 2'b00; r_n = 2'b11; ld = 2'b00; wv = '0;
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        check("R1 q0", int'(q), 0);
        check("R1 qn", int'(q_n), 3);
        watch(0, 8, rs, fs, hs);
        check("R1 no pulse after reset", rs, 0);

        // R3 and R6: length sweep on channel 0, falling-edge trigger
        b[0] = 1'b1; idle(5);
        for (int n = 1; n <= 10; n++) begin
            set_width(0, n);
            a_n[0] = 1'b0;
            watch(0, n + 8, rs, fs, hs);
            check("R3 latency", fs, 3);
            check("R6 width", hs, n);
            check("R3 single pulse", rs, 1);
            a_n[0] = 1'b1; idle(3);
        end

        // R4: rising-edge trigger on channel 1
        a_n[1] = 1'b0; idle(5);
        for (int k = 0; k < 3; k++) begin
            int n;
            n = (k == 0) ? 1 : (k == 1) ? 5 : 16;
            set_width(1, n);
            b[1] = 1'b1;
            watch(1, n + 8, rs, fs, hs);
            check("R4 latency", fs, 3);
            check("R4 width", hs, n);
            b[1] = 1'b0; idle(3);
        end

        // R5 (with R3/R4 fire cases): all before/after trigger level pairs
        set_width(0, 3);
        for (int c = 0; c < 16; c++) begin
            logic a0, b0, a1, b1;
            int   exp;
            a0 = c[3]; b0 = c[2]; a1 = c[1]; b1 = c[0];
            a_n[0] = a0; b[0] = b0; idle(12);
            a_n[0] = a1; b[0] = b1;
            exp = int'((a0 & ~a1 & b1) | (~b0 & b1 & ~a1));
            watch(0, 10, rs, fs, hs);
            check("R5 gating", rs, exp);
            if (exp == 1) check("R5 gated width", hs, 3);
        end

        // R6: zero length gives no pulse
        set_width(0, 0);
        a_n[0] = 1'b1; b[0] = 1'b1; idle(5);
        a_n[0] = 1'b0;
        watch(0, 10, rs, fs, hs);
        check("R6 zero width", rs, 0);

        // R7: retrigger during pulse is ignored
        set_width(0, 10);
        a_n[0] = 1'b1; idle(5);
        a_n[0] = 1'b0;
        watch(0, 4, rs, fs, hs);
        a_n[0] = 1'b1;
        watch(0, 2, r2, f2, h2);
        a_n[0] = 1'b0;
        watch(0, 20, r3, f3, h3);
        check("R7 no stretch", hs + h2 + h3, 10);
        check("R7 one pulse", rs + r2 + r3, 1);

        // R8: clear cuts a pulse, then blocks triggers
        set_width(0, 20);
        a_n[0] = 1'b1; idle(5);
        a_n[0] = 1'b0;
        watch(0, 5, rs, fs, hs);
        check("R8 running", hs, 3);
        r_n[0] = 1'b0;
        watch(0, 3, rs, fs, hs);
        check("R8 cut latency", hs, 2);
        check("R8 q low", int'(q[0]), 0);
        a_n[0] = 1'b1; idle(4);
        a_n[0] = 1'b0;
        watch(0, 8, rs, fs, hs);
        check("R8 blocked while low", rs, 0);

        // R9: sequence above (A high, then A low with B high) armed the release
        r_n[0] = 1'b1;
        watch(0, 26, rs, fs, hs);
        check("R9 release fires", rs, 1);
        check("R9 release latency", fs, 3);
        check("R9 release width", hs, 20);

        // R9: no disturbance while low, no pulse on release
        r_n[0] = 1'b0; idle(6);
        r_n[0] = 1'b1;
        watch(0, 10, rs, fs, hs);
        check("R9 unarmed release", rs, 0);

        // R9: renewed disturbance cancels arming
        r_n[0] = 1'b0;
        a_n[0] = 1'b1; idle(3);
        a_n[0] = 1'b0; idle(3);
        b[0] = 1'b0; idle(3);
        r_n[0] = 1'b1;
        watch(0, 10, rs, fs, hs);
        check("R9 disarmed release", rs, 0);

        // R10: trigger edge coincident with release
        set_width(0, 4);
        r_n[0] = 1'b0; a_n[0] = 1'b1; b[0] = 1'b1; idle(5);
        r_n[0] = 1'b1; a_n[0] = 1'b0;
        watch(0, 10, rs, fs, hs);
        check("R10 zero recovery", rs, 1);
        check("R10 latency", fs, 3);

        // R11: channel 1 held clear while channel 0 fires
        set_width(0, 5);
        r_n[1] = 1'b0; a_n[0] = 1'b1; idle(6);
        a_n[0] = 1'b0;
        watch(0, 12, rs, fs, hs);
        check("R11 ch0 width", hs, 5);
        check("R11 ch1 idle q", int'(q[1]), 0);
        check("R11 ch1 idle qn", int'(q_n[1]), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule